// File: doc/BRIEF.md
# Voice Block Playlist Sequencer

This block plays one voice group at a time. A voice group is not stored as a single stretch of sample memory. It is a list of fixed-length voice blocks, and the same stored block may appear in several lists, so a group can play for longer without storing its data twice. A group-pointer ROM gives, for each group, where its list starts in a shared block-combination ROM, how many entries the list has, and whether the group's data is raw PCM or 4-bit ADPCM.

After a start pulse the sequencer steps through the list in order. On every sample-rate tick it issues one sample-memory byte address and a valid strobe. It also says which nibble of the byte applies when the group is ADPCM. It keeps `busy` high while a group plays. It pulses `done` when the list runs out, when a stop request takes effect, or when the group selected is empty. Both ROMs are built into the block as constant tables that are computed at elaboration.

Top module: `pls_sequencer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `busy`, `done` and `samp_valid` are 0.
- R2: Group g (5-bit `group`) has a list that begins at table index g and holds g mod 4 entries. Its data is ADPCM when g is odd and PCM when g is even. `adpcm` shows this (1 = ADPCM) from the cycle after the start that loads the group.
- R3: Table entry i holds block number (7·i + 3) mod 64. A block spans 4 bytes. In PCM, sample s of a block (s = 0..3) reads byte address block·4 + s, one byte for each tick.
- R4: In ADPCM a block has 8 samples. Sample s reads byte address block·4 + s/2, with `samp_nib_hi` = s mod 2, so the low nibble comes first. `samp_nib_hi` is 0 for PCM samples.
- R5: While `busy` is high, each `tick` gives exactly one `samp_valid` pulse, in the next cycle. No `samp_valid` appears without a tick.
- R6: Entries play in ascending table order and each block plays from its first sample. `done` pulses and `busy` falls in the same cycle as the valid strobe of the last sample of the last entry.
- R7: A start for a group with zero entries pulses `done` in the next cycle, and `busy` stays 0.
- R8: A `stop` seen while busy is held until the next tick, which may be the same cycle. At that tick no sample is issued, `busy` clears and `done` pulses for one cycle.
- R9: A `start` while busy with `restart` low has no effect. Playback continues with the same group and the same address sequence.
- R10: A `start` with `restart` high while busy loads the new group on the next clock. The next tick issues that group's first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start playing the group on `group` |
| restart | input | 1 | Allows `start` to cut in while busy |
| stop | input | 1 | Request to end playback at the next tick |
| group | input | 5 | Voice group number |
| tick | input | 1 | Sample-rate tick |
| samp_addr | output | 8 | Sample-memory byte address |
| samp_nib_hi | output | 1 | ADPCM nibble select, 1 = high nibble |
| samp_valid | output | 1 | Sample address strobe |
| adpcm | output | 1 | Compression mode of the loaded group, 1 = ADPCM |
| busy | output | 1 | A group is playing |
| done | output | 1 | One-cycle end-of-playback pulse |

## Verification
End of playback can be triggered two ways in the same tick cycle: a stop request, and the last sample of the last block. The bench makes these collide by raising `stop` together with the tick that would issue the final ADPCM sample of a one-block group. It expects no sample strobe and a single `done` pulse. A restart that cuts in mid-block is also checked, to confirm that the next address comes from the new group at offset zero and not from the old offset.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
// pls_pkg: shared constants and the ROM content rules for the playlist sequencer.
// Assumes the contents are fixed at elaboration. The functions are only evaluated
// for constant arguments.
package pls_pkg;
    typedef enum logic {MODE_PCM = 1'b0, MODE_ADPCM = 1'b1} mode_e;

    // First table index of group g.
    function automatic int grp_first_f(input int g, input int depth);
        return g % depth;
    endfunction

    // Number of table entries of group g.
    function automatic int grp_count_f(input int g);
        return g % 4;
    endfunction

    // Block number held by table entry i.
    function automatic int blk_of_f(input int i, input int nblocks);
        return (i * 7 + 3) % nblocks;
    endfunction
endpackage

// File: rtl/pls_group_rom.sv
`timescale 1ns/1ps
// pls_group_rom: constant group-pointer table. Gives the first index, the entry
// count and the compression mode of a group.
// Assumes the group index is always below GROUPS.
module pls_group_rom #(
    parameter int GROUPS      = 32,
    parameter int TABLE_DEPTH = 960,
    localparam int GRP_W      = $clog2(GROUPS),
    localparam int PTR_W      = $clog2(TABLE_DEPTH),
    localparam int CNT_W      = $clog2(TABLE_DEPTH + 1)
) (
    input  logic [GRP_W-1:0] grp,
    output logic [PTR_W-1:0] first,
    output logic [CNT_W-1:0] count,
    output pls_pkg::mode_e   mode
);
    logic [PTR_W-1:0] first_mem [GROUPS];
    logic [CNT_W-1:0] count_mem [GROUPS];
    pls_pkg::mode_e   mode_mem  [GROUPS];

    // One constant entry per group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_entry
        assign first_mem[g] = PTR_W'(pls_pkg::grp_first_f(g, TABLE_DEPTH));
        assign count_mem[g] = CNT_W'(pls_pkg::grp_count_f(g));
        assign mode_mem[g]  = (g % 2 == 1) ? pls_pkg::MODE_ADPCM : pls_pkg::MODE_PCM;
    end

    // Asynchronous read port.
    always_comb begin
        first = first_mem[grp];
        count = count_mem[grp];
        mode  = mode_mem[grp];
    end
endmodule

// File: rtl/pls_block_rom.sv
`timescale 1ns/1ps
// pls_block_rom: constant block-combination table. Each entry names one stored
// block. Reads beyond the table depth return block 0.
module pls_block_rom #(
    parameter int TABLE_DEPTH = 960,
    parameter int NUM_BLOCKS  = 64,
    localparam int PTR_W      = $clog2(TABLE_DEPTH),
    localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic [PTR_W-1:0] idx,
    output logic [BLK_W-1:0] blk
);
    logic [BLK_W-1:0] mem [TABLE_DEPTH];

    // Fill every entry from the content rule.
    for (genvar i = 0; i < TABLE_DEPTH; i++) begin : g_entry
        assign mem[i] = BLK_W'(pls_pkg::blk_of_f(i, NUM_BLOCKS));
    end

    // Asynchronous read with range guard.
    always_comb blk = (int'(idx) < TABLE_DEPTH) ? mem[idx] : '0;
endmodule

// File: rtl/pls_addr_gen.sv
`timescale 1ns/1ps
// pls_addr_gen: turns a block number and an in-block sample offset into a byte
// address and a nibble select. It also flags the last sample of the block.
// Assumes BLOCK_BYTES is a power of two. In ADPCM two samples share each byte.
module pls_addr_gen #(
    parameter int NUM_BLOCKS  = 64,
    parameter int BLOCK_BYTES = 4,
    localparam int BLK_W      = $clog2(NUM_BLOCKS),
    localparam int OFF_W      = $clog2(2 * BLOCK_BYTES),
    localparam int ADDR_W     = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
    input  logic [BLK_W-1:0]  blk,
    input  logic [OFF_W-1:0]  off,
    input  pls_pkg::mode_e    mode,
    output logic [ADDR_W-1:0] addr,
    output logic              nib_hi,
    output logic              last
);
    logic [OFF_W-1:0] byte_off;

    // Byte offset and nibble choice depend on the mode.
    always_comb begin
        byte_off = (mode == pls_pkg::MODE_ADPCM) ? (off >> 1) : off;
        nib_hi   = (mode == pls_pkg::MODE_ADPCM) & off[0];
        addr     = ADDR_W'(blk) * ADDR_W'(BLOCK_BYTES) + ADDR_W'(byte_off);
        last     = (mode == pls_pkg::MODE_ADPCM) ? (off == OFF_W'(2 * BLOCK_BYTES - 1))
                                                 : (off == OFF_W'(BLOCK_BYTES - 1));
    end
endmodule

// File: rtl/pls_sequencer.sv
`timescale 1ns/1ps
// pls_sequencer: walks the block list of one voice group and issues one sample
// address per tick, then ends with a done pulse.
// Assumes tick is a single-cycle strobe, and that start with restart takes
// priority over a tick in the same cycle.
module pls_sequencer #(
    parameter int GROUPS      = 32,
    parameter int TABLE_DEPTH = 960,
    parameter int NUM_BLOCKS  = 64,
    parameter int BLOCK_BYTES = 4,
    localparam int GRP_W      = $clog2(GROUPS),
    localparam int PTR_W      = $clog2(TABLE_DEPTH),
    localparam int CNT_W      = $clog2(TABLE_DEPTH + 1),
    localparam int BLK_W      = $clog2(NUM_BLOCKS),
    localparam int OFF_W      = $clog2(2 * BLOCK_BYTES),
    localparam int ADDR_W     = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              restart,
    input  logic              stop,
    input  logic [GRP_W-1:0]  group,
    input  logic              tick,
    output logic [ADDR_W-1:0] samp_addr,
    output logic              samp_nib_hi,
    output logic              samp_valid,
    output logic              adpcm,
    output logic              busy,
    output logic              done
);
    logic [PTR_W-1:0]  g_first;
    logic [CNT_W-1:0]  g_count;
    pls_pkg::mode_e    g_mode;
    logic [PTR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [OFF_W-1:0]  off_q;
    pls_pkg::mode_e    mode_q;
    logic              stop_pend_q;
    logic [BLK_W-1:0]  cur_blk;
    logic [ADDR_W-1:0] nxt_addr;
    logic              nxt_nib, blk_last, load;

    pls_group_rom #(.GROUPS(GROUPS), .TABLE_DEPTH(TABLE_DEPTH)) u_grp (
        .grp(group), .first(g_first), .count(g_count), .mode(g_mode));

    pls_block_rom #(.TABLE_DEPTH(TABLE_DEPTH), .NUM_BLOCKS(NUM_BLOCKS)) u_blk (
        .idx(ptr_q), .blk(cur_blk));

    pls_addr_gen #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_addr (
        .blk(cur_blk), .off(off_q), .mode(mode_q),
        .addr(nxt_addr), .nib_hi(nxt_nib), .last(blk_last));

    // A start loads a group when idle, or at any time when restart is high.
    always_comb load = start & (~busy | restart);

    // Playback state machine: load, step per tick, end on list exhaustion or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            done        <= 1'b0;
            samp_valid  <= 1'b0;
            samp_addr   <= '0;
            samp_nib_hi <= 1'b0;
            ptr_q       <= '0;
            remain_q    <= '0;
            off_q       <= '0;
            mode_q      <= pls_pkg::MODE_PCM;
            stop_pend_q <= 1'b0;
        end else begin
            done       <= 1'b0;
            samp_valid <= 1'b0;
            if (load) begin
                stop_pend_q <= 1'b0;
                mode_q      <= g_mode;
                ptr_q       <= g_first;
                remain_q    <= g_count;
                off_q       <= '0;
                busy        <= (g_count != '0);
                done        <= (g_count == '0);
            end else if (busy) begin
                if (stop) stop_pend_q <= 1'b1;
                if (tick) begin
                    if (stop | stop_pend_q) begin
                        busy        <= 1'b0;
                        done        <= 1'b1;
                        stop_pend_q <= 1'b0;
                    end else begin
                        samp_valid  <= 1'b1;
                        samp_addr   <= nxt_addr;
                        samp_nib_hi <= nxt_nib;
                        if (blk_last) begin
                            off_q <= '0;
                            if (remain_q == CNT_W'(1)) begin
                                busy <= 1'b0;
                                done <= 1'b1;
                            end else begin
                                ptr_q    <= ptr_q + PTR_W'(1);
                                remain_q <= remain_q - CNT_W'(1);
                            end
                        end else begin
                            off_q <= off_q + OFF_W'(1);
                        end
                    end
                end
            end
        end
    end

    // Mode flag of the loaded group.
    always_comb adpcm = (mode_q == pls_pkg::MODE_ADPCM);
endmodule

// File: rtl/pls_sequencer_checker.sv
`timescale 1ns/1ps
// pls_sequencer_checker: temporal properties of the playlist sequencer ports.
// Bound to every instance of pls_sequencer.
module pls_sequencer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       restart,
    input logic       stop,
    input logic [4:0] group,
    input logic       tick,
    input logic       samp_nib_hi,
    input logic       samp_valid,
    input logic       adpcm,
    input logic       busy,
    input logic       done
);
    // A strobe needs a tick one cycle earlier while playing.
    assert_valid_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |-> ($past(tick) && $past(busy)));

    // PCM never selects the high nibble.
    assert_pcm_low_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && !adpcm) |-> !samp_nib_hi);

    // Done lasts one cycle and never overlaps busy.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // Empty group ends at once.
    assert_empty_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (!busy || restart) && group[1:0] == 2'b00) |=> (done && !busy));

    // Stop with tick ends playback without a sample.
    assert_stop_at_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && stop && !start) |=> (done && !samp_valid && !busy));

    // A plain start while busy changes nothing.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !restart && !tick && !stop) |=> (busy && $stable(adpcm)));

    // Restart reloads the mode of the new group.
    assert_restart_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && restart) |=> (adpcm == $past(group[0])));
endmodule

bind pls_sequencer pls_sequencer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .restart(restart), .stop(stop),
    .group(group), .tick(tick), .samp_nib_hi(samp_nib_hi), .samp_valid(samp_valid),
    .adpcm(adpcm), .busy(busy), .done(done));

// File: tb/pls_sequencer_test.sv
`timescale 1ns/1ps
// pls_sequencer_test: plays a table of groups in full, then runs directed cases
// for reset, stop, ignored start and restart.
module pls_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, restart = 1'b0, stop = 1'b0, tick = 1'b0;
    logic [4:0] group = '0;
    logic [7:0] samp_addr;
    logic       samp_nib_hi, samp_valid, adpcm, busy, done;
    int         errors = 0, checks = 0;

    pls_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .restart(restart), .stop(stop),
        .group(group), .tick(tick), .samp_addr(samp_addr), .samp_nib_hi(samp_nib_hi),
        .samp_valid(samp_valid), .adpcm(adpcm), .busy(busy), .done(done));

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Vector table: group to play in full, and its expected total sample count.
    localparam int NVEC = 6;
    localparam int VEC_GRP [NVEC] = '{1, 2, 3, 6, 31, 8};
    localparam int VEC_N   [NVEC] = '{8, 8, 24, 8, 24, 0};

    // Record one check.
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected byte address and nibble for sample n of group g.
    function automatic int exp_addr(input int g, input int n);
        int spb = (g % 2 == 1) ? 8 : 4;
        int blk = (((g + n / spb) * 7) + 3) % 64;
        int s = n % spb;
        return blk * 4 + ((g % 2 == 1) ? s / 2 : s);
    endfunction
    function automatic int exp_nib(input int g, input int n);
        return (g % 2 == 1) ? (n % 8) % 2 : 0;
    endfunction

    // Pulse start with the given restart level, then sample one cycle later.
    task automatic do_start(input int g, input logic r);
        @(negedge clk); group = 5'(g); start = 1'b1; restart = r;
        @(negedge clk); start = 1'b0; restart = 1'b0;
    endtask

    // One tick, with optional stop, and sample the registered result.
    task automatic do_tick(input logic s);
        @(negedge clk); tick = 1'b1; stop = s;
        @(negedge clk); tick = 1'b0; stop = 1'b0;
    endtask

    // Play a whole group and compare every strobe.
    task automatic play_full(input int g, input int n);
        do_start(g, 1'b0);
        chk("R2", "adpcm after start", int'(adpcm), g % 2);
        if (n == 0) begin
            chk("R7", "done for empty group", int'(done), 1);
            chk("R7", "busy for empty group", int'(busy), 0);
        end
        for (int k = 0; k < n; k++) begin
            do_tick(1'b0);
            chk("R5", "valid per tick", int'(samp_valid), 1);
            chk((g % 2 == 1) ? "R4" : "R3", "address", int'(samp_addr), exp_addr(g, k));
            chk("R4", "nibble select", int'(samp_nib_hi), exp_nib(g, k));
            chk("R6", "done at end", int'(done), (k == n - 1) ? 1 : 0);
            chk("R6", "busy during play", int'(busy), (k == n - 1) ? 0 : 1);
        end
        do_tick(1'b0);
        chk("R5", "no strobe when idle", int'(samp_valid), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "valid in reset", int'(samp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "busy after reset", int'(busy), 0);

        // Table walk over groups of both modes and several lengths.
        for (int v = 0; v < NVEC; v++) play_full(VEC_GRP[v], VEC_N[v]);

        // R8: a stop is held until the next tick.
        do_start(3, 1'b0);
        for (int k = 0; k < 5; k++) do_tick(1'b0);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk("R8", "busy held until tick", int'(busy), 1);
        chk("R8", "no done before tick", int'(done), 0);
        do_tick(1'b0);
        chk("R8", "no sample at stop tick", int'(samp_valid), 0);
        chk("R8", "done at stop tick", int'(done), 1);
        chk("R8", "busy cleared", int'(busy), 0);
        do_tick(1'b0);
        chk("R8", "done is one cycle", int'(done), 0);

        // R8: stop together with the last sample of group 1.
        do_start(1, 1'b0);
        for (int k = 0; k < 7; k++) do_tick(1'b0);
        do_tick(1'b1);
        chk("R8", "stop beats last sample", int'(samp_valid), 0);
        chk("R8", "single done", int'(done), 1);
        chk("R8", "busy after collision", int'(busy), 0);

        // R9: a start without restart is ignored.
        do_start(2, 1'b0);
        do_tick(1'b0);
        do_tick(1'b0);
        do_start(7, 1'b0);
        chk("R9", "busy kept", int'(busy), 1);
        chk("R9", "mode kept", int'(adpcm), 0);
        do_tick(1'b0);
        chk("R9", "address continues", int'(samp_addr), exp_addr(2, 2));

        // R10: restart reloads mid-block.
        do_start(1, 1'b1);
        chk("R10", "busy after restart", int'(busy), 1);
        chk("R10", "mode after restart", int'(adpcm), 1);
        do_tick(1'b0);
        chk("R10", "first address", int'(samp_addr), exp_addr(1, 0));
        chk("R10", "first nibble", int'(samp_nib_hi), 0);
        do_tick(1'b0);
        chk("R4", "second nibble", int'(samp_nib_hi), 1);
        chk("R4", "same byte", int'(samp_addr), exp_addr(1, 1));

        // R7 and R10: restart into an empty group.
        do_start(4, 1'b1);
        chk("R7", "done on empty restart", int'(done), 1);
        chk("R7", "busy dropped", int'(busy), 0);
        do_tick(1'b0);
        chk("R5", "no strobe after empty", int'(samp_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule